// File: doc/BRIEF.md
# Indirect Configuration Port Decoder

This block sits in a host bridge on the CPU's I/O path. It provides the indirect configuration access scheme. Software first writes a 32-bit selector word to a fixed I/O port. The selector names a bus, a device, a function and a dword register, and its top bit turns the scheme on. Software then reads or writes a four-byte data window. Each access to the window becomes one configuration request toward a downstream responder. The request carries the decoded target, the byte enables, the direction and the write data placed on the correct lanes.

The CPU side uses a hold-until-acknowledge protocol. The CPU raises `io_valid` with a stable address, size, direction and write data. It keeps them until `io_ready` pulses for one cycle, and it must drop `io_valid` in the cycle after that pulse. Access sizes are 1, 2 or 4 bytes. Read data is returned right-justified. The block stalls the CPU while a configuration request is outstanding. The responder completes a request by raising `cfg_ready`, with the read dword present in that same cycle.

Top module: `cfgp_top`

## Requirements
- R1: After reset, the selector register is zero, `cfg_valid` is low and `io_ready` is low. A dword read of the selector port then returns 0.
- R2: A dword write to the selector port (0xCF8) stores the written word with bits 1:0 forced to zero. A later dword read of that port returns the stored word, so 0x80000000 reads back as 0x80000000.
- R3: A byte or word access anywhere in 0xCF8–0xCFB is not claimed. It leaves the selector unchanged and makes no request. A read returns ones over the access width.
- R4: A request's target comes from the selector as follows: bus = bits 23:16, device = bits 15:11, function = bits 10:8, dword register = bits 7:2.
- R5: Byte enables (bit n = byte lane n) are derived from the access. A byte access at 0xCFC+n gives 1<<n. A word access at 0xCFC or 0xCFE gives 4'b0011 or 4'b1100. A dword access at 0xCFC gives 4'b1111.
- R6: Write data, right-justified on `io_wdata`, appears on `cfg_wdata` shifted left by 8 times the byte offset, and `cfg_write` is 1.
- R7: Read data returned to the CPU is `cfg_rdata` shifted right by 8 times the byte offset. It is masked to the access width, and the bits above that width are zero.
- R8: While selector bit 31 is clear, window accesses make no request. Reads return ones over the access width, and writes have no effect.
- R9: A request holds `cfg_valid` and all its fields until `cfg_ready`. `io_ready` pulses for exactly one cycle, one cycle after the handshake. An access whose responder waits d cycles completes d+2 cycles after `io_valid` is first sampled.
- R10: Misaligned window accesses are not claimed. These are a word at an odd offset, a dword at a non-zero offset, a size code of 3, and any address outside 0xCF8–0xCFF. Each one completes one cycle after it is sampled, returns ones over its width and makes no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | CPU I/O access present, held until io_ready |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | AW (16) | I/O byte address |
| io_size | input | 2 | 0 = byte, 1 = word, 2 = dword, 3 = reserved |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | One-cycle completion pulse |
| io_rdata | output | 32 | Right-justified read data, valid with io_ready |
| cfg_valid | output | 1 | Configuration request pending |
| cfg_ready | input | 1 | Responder completes the request |
| cfg_write | output | 1 | Request direction |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Target dword register index |
| cfg_be | output | 4 | Lane byte enables |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Read dword from responder, valid with cfg_ready |

## Verification
The assertions check the handshake rules on every cycle. A pending request keeps its enables and target until it is accepted. A handshake is always followed by a single-cycle `io_ready`. No request is issued while the enable bit is clear. Every issued enable pattern has 1, 2 or 4 bits set. Only the directed scenarios can show that the values are right: the field extraction from the selector, the exact lane for each offset, the read alignment and masking, the readback of the selector with its low bits cleared, and the rejection of narrow or misaligned accesses.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CFG  = 2'd1,
        ST_DONE = 2'd2
    } cfgp_state_e;

    typedef struct packed {
        cfgp_state_e st;
        logic [31:0] sel;
        logic [31:0] rdata;
    } cfgp_regs_t;
endpackage

// File: rtl/cfgp_port_decode.sv
module cfgp_port_decode #(
    parameter int AW = 16,
    parameter logic [AW-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [AW-1:0] WIN_PORT = 16'h0CFC
) (
    input  logic [AW-1:0] addr,
    output logic          hit_sel,
    output logic          hit_win,
    output logic [1:0]    offset
);
    // Both ports are dword-aligned, four-byte regions.
    assign hit_sel = (addr[AW-1:2] == SEL_PORT[AW-1:2]);
    assign hit_win = (addr[AW-1:2] == WIN_PORT[AW-1:2]);
    assign offset  = addr[1:0];
endmodule

// File: rtl/cfgp_lane_map.sv
module cfgp_lane_map #(
    parameter int NBYTES = 4,
    localparam int OW = $clog2(NBYTES),
    localparam int DW = NBYTES * 8
) (
    input  logic [OW-1:0]     offset,
    input  logic [1:0]        size,
    input  logic [DW-1:0]     wdata_in,
    input  logic [DW-1:0]     rdata_in,
    output logic              legal,
    output logic [NBYTES-1:0] be,
    output logic [DW-1:0]     wdata_lane,
    output logic [DW-1:0]     rdata_out,
    output logic [DW-1:0]     ones
);
    int nb;
    int off_i;

    always_comb begin
        nb    = 1 << size;
        off_i = int'(offset);
        legal = (nb <= NBYTES) && ((off_i % nb) == 0);
        for (int i = 0; i < NBYTES; i++) begin
            be[i]          = (i >= off_i) && (i < off_i + nb);
            ones[i*8 +: 8] = (i < nb) ? 8'hFF : 8'h00;
        end
        wdata_lane = wdata_in << (8 * off_i);
        rdata_out  = (rdata_in >> (8 * off_i)) & ones;
    end
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top #(
    parameter int AW = 16,
    parameter logic [AW-1:0] SEL_PORT = 16'h0CF8,
    parameter logic [AW-1:0] WIN_PORT = 16'h0CFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          io_valid,
    input  logic          io_write,
    input  logic [AW-1:0] io_addr,
    input  logic [1:0]    io_size,
    input  logic [31:0]   io_wdata,
    output logic          io_ready,
    output logic [31:0]   io_rdata,
    output logic          cfg_valid,
    input  logic          cfg_ready,
    output logic          cfg_write,
    output logic [7:0]    cfg_bus,
    output logic [4:0]    cfg_dev,
    output logic [2:0]    cfg_func,
    output logic [5:0]    cfg_reg,
    output logic [3:0]    cfg_be,
    output logic [31:0]   cfg_wdata,
    input  logic [31:0]   cfg_rdata
);
    import cfgp_pkg::*;

    localparam int NBYTES  = 4;
    localparam int EN_BIT  = 31;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    cfgp_regs_t q, d;
    logic        hit_sel, hit_win, legal, sel_en;
    logic [1:0]  offset;
    logic [31:0] rd_aligned, ones;

    cfgp_port_decode #(.AW(AW), .SEL_PORT(SEL_PORT), .WIN_PORT(WIN_PORT)) i_dec (
        .addr    (io_addr),
        .hit_sel (hit_sel),
        .hit_win (hit_win),
        .offset  (offset)
    );

    cfgp_lane_map #(.NBYTES(NBYTES)) i_lane (
        .offset     (offset),
        .size       (io_size),
        .wdata_in   (io_wdata),
        .rdata_in   (cfg_rdata),
        .legal      (legal),
        .be         (cfg_be),
        .wdata_lane (cfg_wdata),
        .rdata_out  (rd_aligned),
        .ones       (ones)
    );

    assign sel_en = q.sel[EN_BIT];

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (io_valid) begin
                    d.st    = ST_DONE;
                    d.rdata = ones;
                    if (hit_sel && io_size == SZ_DWORD) begin
                        if (io_write) begin
                            d.sel   = {io_wdata[31:2], 2'b00};
                            d.rdata = '0;
                        end else begin
                            d.rdata = q.sel;
                        end
                    end else if (hit_win && legal && sel_en) begin
                        d.st = ST_CFG;
                    end
                end
            end
            ST_CFG: begin
                if (cfg_ready) begin
                    d.st    = ST_DONE;
                    d.rdata = io_write ? '0 : rd_aligned;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.sel   <= '0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign io_ready  = (q.st == ST_DONE);
    assign io_rdata  = q.rdata;
    assign cfg_valid = (q.st == ST_CFG);
    assign cfg_write = io_write;
    assign cfg_bus   = q.sel[23:16];
    assign cfg_dev   = q.sel[15:11];
    assign cfg_func  = q.sel[10:8];
    assign cfg_reg   = q.sel[7:2];
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       io_ready,
    input logic       cfg_valid,
    input logic       cfg_ready,
    input logic [3:0] cfg_be,
    input logic [7:0] cfg_bus,
    input logic [5:0] cfg_reg,
    input logic       sel_en
);
    p_single_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_ready |=> !io_ready);

    p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_be)
                                       && $stable(cfg_bus) && $stable(cfg_reg)));

    p_ack_after_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ready) |=> (io_ready && !cfg_valid));

    p_gate_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> sel_en);

    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2
                       || $countones(cfg_be) == 4));
endmodule

bind cfgp_top cfgp_checker i_cfgp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_ready  (io_ready),
    .cfg_valid (cfg_valid),
    .cfg_ready (cfg_ready),
    .cfg_be    (cfg_be),
    .cfg_bus   (cfg_bus),
    .cfg_reg   (cfg_reg),
    .sel_en    (sel_en)
);

// File: tb/test_cfgp_top.sv
module test_cfgp_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_valid = 0, io_write = 0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic [31:0] io_wdata = '0;
    logic        io_ready;
    logic [31:0] io_rdata;
    logic        cfg_valid, cfg_write;
    logic        cfg_ready = 0;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata = '0;

    int n_tests = 0, n_fail = 0;

    // captured by xfer
    logic [31:0] r_data;
    logic        r_cfg;
    int          r_lat;
    logic [7:0]  c_bus;
    logic [4:0]  c_dev;
    logic [2:0]  c_func;
    logic [5:0]  c_reg;
    logic [3:0]  c_be;
    logic [31:0] c_wdata;
    logic        c_write;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgp_top i_cfgp_top (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_ready(io_ready), .io_rdata(io_rdata), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_write(cfg_write), .cfg_bus(cfg_bus),
        .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [15:0] addr, input logic [1:0] size,
                        input logic [31:0] wdata, input int delay,
                        input logic [31:0] resp);
        int waited = 0;
        r_cfg = 0;
        r_lat = 0;
        @(negedge clk);
        io_valid = 1; io_write = wr; io_addr = addr; io_size = size; io_wdata = wdata;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            r_lat++;
            cfg_ready = 0;
            if (io_ready) begin
                r_data = io_rdata;
                io_valid = 0;
                return;
            end
            if (cfg_valid) begin
                r_cfg = 1;
                c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func; c_reg = cfg_reg;
                c_be = cfg_be; c_wdata = cfg_wdata; c_write = cfg_write;
                if (waited == delay) begin
                    cfg_ready = 1;
                    cfg_rdata = resp;
                end
                waited++;
            end
        end
        io_valid = 0;
        check(0, "watchdog", 32'(r_lat), 0);
    endtask

    task automatic t_reset();
        check(io_ready == 0, "R1 io_ready", 32'(io_ready), 0);
        check(cfg_valid == 0, "R1 cfg_valid", 32'(cfg_valid), 0);
        xfer(0, 16'h0CF8, 2, 0, 0, 0);
        check(r_data == 0, "R1 selector reset", r_data, 0);
    endtask

    task automatic t_selector();
        xfer(1, 16'h0CF8, 2, 32'h8000_0000, 0, 0);
        xfer(0, 16'h0CF8, 2, 0, 0, 0);
        check(r_data == 32'h8000_0000, "R2 readback", r_data, 32'h8000_0000);
        check(r_lat == 1, "R2 latency", 32'(r_lat), 1);
        xfer(1, 16'h0CF8, 2, 32'h8012_AB7F, 0, 0);
        xfer(0, 16'h0CF8, 2, 0, 0, 0);
        check(r_data == 32'h8012_AB7C, "R2 low bits cleared", r_data, 32'h8012_AB7C);
    endtask

    task automatic t_narrow_selector();
        xfer(1, 16'h0CF9, 0, 32'hFF, 0, 0);
        check(!r_cfg, "R3 byte write no request", 32'(r_cfg), 0);
        xfer(0, 16'h0CFA, 1, 0, 0, 0);
        check(r_data == 32'h0000_FFFF, "R3 word read ones", r_data, 32'h0000_FFFF);
        xfer(0, 16'h0CF8, 2, 0, 0, 0);
        check(r_data == 32'h8012_AB7C, "R3 selector unchanged", r_data, 32'h8012_AB7C);
    endtask

    task automatic t_fields();
        xfer(1, 16'h0CF8, 2, 32'h80A5_5B3C, 0, 0);
        xfer(0, 16'h0CFC, 2, 0, 3, 32'hCAFE_F00D);
        check(r_cfg, "R4 request issued", 32'(r_cfg), 1);
        check(c_bus == 8'hA5, "R4 bus", 32'(c_bus), 32'hA5);
        check(c_dev == 5'h0B, "R4 device", 32'(c_dev), 32'h0B);
        check(c_func == 3'd3, "R4 function", 32'(c_func), 3);
        check(c_reg == 6'h0F, "R4 register", 32'(c_reg), 32'h0F);
        check(c_be == 4'hF, "R5 dword be", 32'(c_be), 32'hF);
        check(c_write == 0, "R7 read direction", 32'(c_write), 0);
        check(r_data == 32'hCAFE_F00D, "R7 dword data", r_data, 32'hCAFE_F00D);
        check(r_lat == 5, "R9 latency delay 3", 32'(r_lat), 5);
        xfer(0, 16'h0CFC, 2, 0, 0, 32'h1234_5678);
        check(r_lat == 2, "R9 latency delay 0", 32'(r_lat), 2);
    endtask

    task automatic t_bytes();
        for (int n = 0; n < 4; n++) begin
            xfer(0, 16'h0CFC + 16'(n), 0, 0, n, 32'h4433_2211);
            check(c_be == 4'(1 << n), "R5 byte be", 32'(c_be), 32'(1 << n));
            check(r_data == ((32'h4433_2211 >> (8*n)) & 32'hFF), "R7 byte data",
                  r_data, (32'h4433_2211 >> (8*n)) & 32'hFF);
        end
        xfer(1, 16'h0CFE, 0, 32'hFFFF_FFAB, 1, 0);
        check(c_write == 1, "R6 write direction", 32'(c_write), 1);
        check(c_wdata[23:16] == 8'hAB && c_be == 4'b0100, "R6 byte lane 2",
              c_wdata, 32'hxxAB_xxxx);
    endtask

    task automatic t_words();
        xfer(0, 16'h0CFE, 1, 0, 2, 32'h4433_2211);
        check(c_be == 4'b1100, "R5 upper word be", 32'(c_be), 32'hC);
        check(r_data == 32'h0000_4433, "R7 upper word data", r_data, 32'h4433);
        xfer(1, 16'h0CFC, 1, 32'h0000_BEEF, 0, 0);
        check(c_be == 4'b0011, "R5 lower word be", 32'(c_be), 32'h3);
        check(c_wdata[15:0] == 16'hBEEF, "R6 lower word lane", c_wdata, 32'hBEEF);
        xfer(1, 16'h0CFE, 1, 32'h0000_1357, 0, 0);
        check(c_wdata[31:16] == 16'h1357, "R6 upper word lane", c_wdata, 32'h1357_0000);
    endtask

    task automatic t_disabled();
        xfer(1, 16'h0CF8, 2, 32'h0012_AB00, 0, 0);
        xfer(0, 16'h0CFD, 0, 0, 0, 32'h0);
        check(!r_cfg, "R8 byte read no request", 32'(r_cfg), 0);
        check(r_data == 32'hFF, "R8 byte read ones", r_data, 32'hFF);
        xfer(0, 16'h0CFC, 2, 0, 0, 32'h0);
        check(r_data == 32'hFFFF_FFFF, "R8 dword read ones", r_data, 32'hFFFF_FFFF);
        xfer(1, 16'h0CFC, 2, 32'h1111_1111, 0, 0);
        check(!r_cfg, "R8 write dropped", 32'(r_cfg), 0);
        check(r_lat == 1, "R8 latency", 32'(r_lat), 1);
    endtask

    task automatic t_misaligned();
        xfer(1, 16'h0CF8, 2, 32'h8000_0100, 0, 0);
        xfer(0, 16'h0CFD, 1, 0, 0, 32'h0);
        check(!r_cfg && r_data == 32'hFFFF, "R10 odd word", r_data, 32'hFFFF);
        xfer(0, 16'h0CFF, 1, 0, 0, 32'h0);
        check(!r_cfg && r_data == 32'hFFFF, "R10 word at last byte", r_data, 32'hFFFF);
        xfer(0, 16'h0CFE, 2, 0, 0, 32'h0);
        check(!r_cfg && r_data == 32'hFFFF_FFFF, "R10 offset dword", r_data, 32'hFFFF_FFFF);
        xfer(0, 16'h0CFC, 3, 0, 0, 32'h0);
        check(!r_cfg, "R10 size code 3", 32'(r_cfg), 0);
        xfer(0, 16'h0080, 0, 0, 0, 32'h0);
        check(!r_cfg && r_data == 32'hFF, "R10 foreign address", r_data, 32'hFF);
        check(r_lat == 1, "R10 latency", 32'(r_lat), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_selector();
        t_narrow_selector();
        t_fields();
        t_bytes();
        t_words();
        t_disabled();
        t_misaligned();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule